// File: doc/BRIEF.md
# Reframe Request Host Sequencer

This block is the supervisory sequencer that sits above a byte-boundary reframe controller. After power-up, and every time the transmit source is switched, it asks the reframe controller for a full reframe. The request is a level that stays high until the controller reports completion on a done line. The sequencer answers done with an acknowledge, and it drops the request on that same clock edge so that the controller, once back in idle, does not begin a second reframe.

A separate force line asks the receiver for the stronger multibyte framing mode, which needs the reframe pin held for a fixed run of cycles. When the host asks for it, the sequencer drives the force line high for exactly `FORCE_LEN` (2048) cycles. Force and handshake reframes never overlap. A request that arrives while the other kind is in progress waits in a pending flag until the sequencer is idle again. If both kinds are pending, the handshake reframe goes first.

The sequencer also watches the registered error-type flags from the reframe controller. It counts running-disparity errors and undefined-character errors in saturating counters. A cycle that shows both types at once breaks the protocol, and it is counted as a fault instead. The flags are used only in a cycle when the error input is high.

Top module: `reframe_host_seq`

## Requirements
- R1: After `rst_n` deasserts, `enable_o` is low, and it rises at the 6th rising edge: 2 edges of reset synchronisation, then 4 enable-delay cycles. From then on it stays high until the next reset.
- R2: In idle with `enable_o` high, a pending reframe raises `request_o` at the next edge. One reframe is pending out of reset. A `link_event_i` pulse sampled at one edge makes another pending, so `request_o` rises at the following edge. `request_o` stays high for as long as `done_i` stays low.
- R3: At an edge where `request_o` and `done_i` are both high, `request_o` falls and `ack_o` rises on that same edge.
- R4: `ack_o` stays high while `done_i` is high. It falls at the first edge that samples `done_i` low. `request_o` does not rise again before the edge after the one where `ack_o` falls.
- R5: A `mb_req_i` pulse makes a multibyte request pending. In idle, this drives `force_o` high for exactly 2048 consecutive cycles, after which it is released.
- R6: Requests that arrive while the other kind is running are queued. A `mb_req_i` during a handshake makes `force_o` rise at the edge after `ack_o` falls. A `link_event_i` during a force run makes `request_o` rise at the edge after `force_o` falls. When both kinds are pending in idle, the handshake reframe goes first.
- R7: At an edge with `err_i`=1, `rdisp_i`=1 and `undef_i`=0, `rdisp_cnt_o` increments by one. At an edge with `err_i`=1, `undef_i`=1 and `rdisp_i`=0, `undef_cnt_o` increments by one.
- R8: With `err_i`=0, the values on `rdisp_i` and `undef_i` change none of the three counters.
- R9: At an edge with `err_i`, `rdisp_i` and `undef_i` all high, `fault_cnt_o` increments, and neither type counter changes.
- R10: Each counter is 16 bits wide. It stops at 65535 and holds that value.
- R11: At most one of `request_o`, `ack_o` and `force_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_event_i | input | 1 | Power-up or transmit-source-switch event, one-cycle pulse |
| mb_req_i | input | 1 | Multibyte framing request, one-cycle pulse |
| done_i | input | 1 | Reframe-complete handshake from the reframe controller |
| err_i | input | 1 | Registered error indication |
| rdisp_i | input | 1 | Registered running-disparity error flag |
| undef_i | input | 1 | Registered undefined-character error flag |
| enable_o | output | 1 | Enable to the reframe controller |
| request_o | output | 1 | Level reframe request |
| force_o | output | 1 | Force line to the reframe pin |
| ack_o | output | 1 | Acknowledge of the done handshake |
| rdisp_cnt_o | output | 16 | Saturating running-disparity error count |
| undef_cnt_o | output | 16 | Saturating undefined-character error count |
| fault_cnt_o | output | 16 | Saturating count of both-flags protocol faults |

## Verification
All results come from registers, so each one is due at the first rising edge that samples its stimulus. The exceptions are a newly pending request, which takes a second edge (flag, then launch), and `enable_o`, which is due 6 edges after reset release. The reference model in the bench steps once per rising edge on the input values held since the previous falling edge, and it is compared with the outputs 1 ns after that edge. Directed checks drive inputs on a falling edge and read results on a later falling edge, counted edge by edge. This covers the done-to-acknowledge edge, the queued start after acknowledge or force release, and the 2048-cycle force run.

// File: rtl/reframe_host_pkg.sv
package reframe_host_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_ACK   = 2'd2,
    HS_FORCE = 2'd3
  } hs_state_e;

  localparam int ERR_KINDS  = 3;
  localparam int KIND_RDISP = 0;
  localparam int KIND_UNDEF = 1;
  localparam int KIND_FAULT = 2;

endpackage

// File: rtl/rhs_rst_sync.sv
module rhs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/rhs_enable_timer.sv
module rhs_enable_timer #(
  parameter int DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic enable_o
);

  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, en_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    en_d   = en_q;
    if (!en_q) begin
      if (cnt_q == CW'(DELAY - 1)) begin
        en_d = 1'b1;
      end else begin
        cnt_ce = 1'b1;
        cnt_d  = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
      en_q <= en_d;
    end
  end

  assign enable_o = en_q;

endmodule

// File: rtl/rhs_force_timer.sv
module rhs_force_timer #(
  parameter int LEN = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);

  localparam int TW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = run_i || (cnt_q != '0);
    cnt_d  = run_i ? (cnt_q + TW'(1)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = run_i && (cnt_q == TW'(LEN - 1));

endmodule

// File: rtl/rhs_handshake_fsm.sv
module rhs_handshake_fsm
  import reframe_host_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic link_event_i,
  input  logic mb_req_i,
  input  logic done_i,
  input  logic force_last_i,
  output logic request_o,
  output logic ack_o,
  output logic force_o
);

  hs_state_e state_q, state_d;
  logic      rf_pend_q, rf_pend_d;
  logic      mb_pend_q, mb_pend_d;
  logic      launch_rf, launch_mb;

  always_comb begin
    state_d   = state_q;
    launch_rf = 1'b0;
    launch_mb = 1'b0;
    unique case (state_q)
      HS_IDLE: begin
        if (enable_i) begin
          if (rf_pend_q) begin
            state_d   = HS_REQ;
            launch_rf = 1'b1;
          end else if (mb_pend_q) begin
            state_d   = HS_FORCE;
            launch_mb = 1'b1;
          end
        end
      end
      HS_REQ: begin
        if (done_i) begin
          state_d = HS_ACK;
        end
      end
      HS_ACK: begin
        if (!done_i) begin
          state_d = HS_IDLE;
        end
      end
      HS_FORCE: begin
        if (force_last_i) begin
          state_d = HS_IDLE;
        end
      end
      default: state_d = HS_IDLE;
    endcase
    rf_pend_d = (rf_pend_q && !launch_rf) || link_event_i;
    mb_pend_d = (mb_pend_q && !launch_mb) || mb_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      rf_pend_q <= 1'b1;
      mb_pend_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rf_pend_q <= rf_pend_d;
      mb_pend_q <= mb_pend_d;
    end
  end

  assign request_o = (state_q == HS_REQ);
  assign ack_o     = (state_q == HS_ACK);
  assign force_o   = (state_q == HS_FORCE);

endmodule

// File: rtl/rhs_sat_counter.sv
module rhs_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_ce = inc_i && (cnt_q != {W{1'b1}});
    cnt_d  = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/rhs_err_counters.sv
module rhs_err_counters
  import reframe_host_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          err_i,
  input  logic                          rdisp_i,
  input  logic                          undef_i,
  output logic [ERR_KINDS-1:0][W-1:0]   counts_o
);

  logic [ERR_KINDS-1:0] hit;

  always_comb begin
    hit             = '0;
    hit[KIND_RDISP] = err_i &&  rdisp_i && !undef_i;
    hit[KIND_UNDEF] = err_i && !rdisp_i &&  undef_i;
    hit[KIND_FAULT] = err_i &&  rdisp_i &&  undef_i;
  end

  for (genvar k = 0; k < ERR_KINDS; k++) begin : g_cnt
    rhs_sat_counter #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (hit[k]),
      .count_o (counts_o[k])
    );
  end

endmodule

// File: rtl/reframe_host_seq.sv
module reframe_host_seq
  import reframe_host_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FORCE_LEN   = 2048,
  parameter int EN_DELAY    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_event_i,
  input  logic             mb_req_i,
  input  logic             done_i,
  input  logic             err_i,
  input  logic             rdisp_i,
  input  logic             undef_i,
  output logic             enable_o,
  output logic             request_o,
  output logic             force_o,
  output logic             ack_o,
  output logic [CNT_W-1:0] rdisp_cnt_o,
  output logic [CNT_W-1:0] undef_cnt_o,
  output logic [CNT_W-1:0] fault_cnt_o
);

  logic                            rst_int_n;
  logic                            force_last;
  logic [ERR_KINDS-1:0][CNT_W-1:0] cnt_all;

  rhs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  rhs_enable_timer #(.DELAY(EN_DELAY)) u_en (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enable_o (enable_o)
  );

  rhs_handshake_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .enable_i     (enable_o),
    .link_event_i (link_event_i),
    .mb_req_i     (mb_req_i),
    .done_i       (done_i),
    .force_last_i (force_last),
    .request_o    (request_o),
    .ack_o        (ack_o),
    .force_o      (force_o)
  );

  rhs_force_timer #(.LEN(FORCE_LEN)) u_ftmr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (force_o),
    .last_o (force_last)
  );

  rhs_err_counters #(.W(CNT_W)) u_err (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .err_i    (err_i),
    .rdisp_i  (rdisp_i),
    .undef_i  (undef_i),
    .counts_o (cnt_all)
  );

  assign rdisp_cnt_o = cnt_all[KIND_RDISP];
  assign undef_cnt_o = cnt_all[KIND_UNDEF];
  assign fault_cnt_o = cnt_all[KIND_FAULT];

endmodule

// File: rtl/reframe_host_seq_chk.sv
module reframe_host_seq_chk #(
  parameter int CNT_W     = 16,
  parameter int FORCE_LEN = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_i,
  input logic             err_i,
  input logic             rdisp_i,
  input logic             undef_i,
  input logic             enable_o,
  input logic             request_o,
  input logic             ack_o,
  input logic             force_o,
  input logic [CNT_W-1:0] rdisp_cnt_o,
  input logic [CNT_W-1:0] undef_cnt_o,
  input logic [CNT_W-1:0] fault_cnt_o
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
    end else begin
      run_len <= force_o ? run_len + 1 : 0;
    end
  end

  assert_enable_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable_o) |-> enable_o);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    request_o && !done_i |=> request_o);

  assert_done_swaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    request_o && done_i |=> ack_o && !request_o);

  assert_ack_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && done_i |=> ack_o);

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && !done_i |=> !ack_o && !request_o);

  assert_req_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(request_o) |-> !$past(ack_o));

  assert_force_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |-> run_len < FORCE_LEN);

  assert_force_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_o) |-> run_len == FORCE_LEN);

  assert_rdisp_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable_o) && $past(err_i) && $past(rdisp_i) && !$past(undef_i)
    && ($past(rdisp_cnt_o) != {CNT_W{1'b1}})
    |-> rdisp_cnt_o == $past(rdisp_cnt_o) + CNT_W'(1));

  assert_undef_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable_o) && $past(err_i) && $past(undef_i) && !$past(rdisp_i)
    && ($past(undef_cnt_o) != {CNT_W{1'b1}})
    |-> undef_cnt_o == $past(undef_cnt_o) + CNT_W'(1));

  assert_no_err_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(err_i) |-> $stable(rdisp_cnt_o) && $stable(undef_cnt_o) && $stable(fault_cnt_o));

  assert_fault_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable_o) && $past(err_i) && $past(rdisp_i) && $past(undef_i)
    |-> $stable(rdisp_cnt_o) && $stable(undef_cnt_o)
        && (fault_cnt_o != $past(fault_cnt_o) || fault_cnt_o == {CNT_W{1'b1}}));

  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rdisp_cnt_o) == {CNT_W{1'b1}}) |-> (rdisp_cnt_o == {CNT_W{1'b1}}));

  assert_one_hot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({request_o, ack_o, force_o}));

endmodule

bind reframe_host_seq reframe_host_seq_chk #(
  .CNT_W     (CNT_W),
  .FORCE_LEN (FORCE_LEN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_i      (done_i),
  .err_i       (err_i),
  .rdisp_i     (rdisp_i),
  .undef_i     (undef_i),
  .enable_o    (enable_o),
  .request_o   (request_o),
  .ack_o       (ack_o),
  .force_o     (force_o),
  .rdisp_cnt_o (rdisp_cnt_o),
  .undef_cnt_o (undef_cnt_o),
  .fault_cnt_o (fault_cnt_o)
);

// File: tb/reframe_host_seq_tb.sv
`timescale 1ns/1ps
module reframe_host_seq_tb;

  localparam int FLEN   = 2048;
  localparam int EN_DLY = 4;
  localparam int CMAX   = 65535;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_event_i, mb_req_i, done_i, err_i, rdisp_i, undef_i;
  logic        enable_o, request_o, force_o, ack_o;
  logic [15:0] rdisp_cnt_o, undef_cnt_o, fault_cnt_o;

  always #2 clk = ~clk;

  reframe_host_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_event_i (link_event_i),
    .mb_req_i     (mb_req_i),
    .done_i       (done_i),
    .err_i        (err_i),
    .rdisp_i      (rdisp_i),
    .undef_i      (undef_i),
    .enable_o     (enable_o),
    .request_o    (request_o),
    .force_o      (force_o),
    .ack_o        (ack_o),
    .rdisp_cnt_o  (rdisp_cnt_o),
    .undef_cnt_o  (undef_cnt_o),
    .fault_cnt_o  (fault_cnt_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference model: phase 0 idle, 1 request, 2 acknowledge, 3 force
  int rel = 0;
  int m_ph = 0;
  int m_fc = 0;
  bit m_en = 0;
  bit m_rfp = 1;
  bit m_mbp = 0;
  int c_rd = 0, c_ud = 0, c_ft = 0;

  always @(posedge clk) begin
    int nph;
    bit lr, lm;
    if (!rst_n) begin
      rel = 0; m_ph = 0; m_fc = 0; m_en = 0; m_rfp = 1; m_mbp = 0;
      c_rd = 0; c_ud = 0; c_ft = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        nph = m_ph; lr = 0; lm = 0;
        case (m_ph)
          0: if (m_en) begin
               if (m_rfp) begin nph = 1; lr = 1; end
               else if (m_mbp) begin nph = 3; lm = 1; m_fc = 0; end
             end
          1: if (done_i) nph = 2;
          2: if (!done_i) nph = 0;
          default: begin
            m_fc++;
            if (m_fc == FLEN) nph = 0;
          end
        endcase
        m_rfp = (m_rfp && !lr) || link_event_i;
        m_mbp = (m_mbp && !lm) || mb_req_i;
        m_ph = nph;
        if (err_i) begin
          if (rdisp_i && undef_i) begin if (c_ft < CMAX) c_ft++; end
          else if (rdisp_i) begin if (c_rd < CMAX) c_rd++; end
          else if (undef_i) begin if (c_ud < CMAX) c_ud++; end
        end
        m_en = ((rel - 2) >= EN_DLY);
      end
    end
    #1;
    chk("R1 enable_o", enable_o, m_en);
    chk("R2 request_o", request_o, m_ph == 1);
    chk("R3 ack_o", ack_o, m_ph == 2);
    chk("R5 force_o", force_o, m_ph == 3);
    chk("R7 rdisp_cnt_o", rdisp_cnt_o, c_rd);
    chk("R7 undef_cnt_o", undef_cnt_o, c_ud);
    chk("R9 fault_cnt_o", fault_cnt_o, c_ft);
    chk("R11 one-hot", (request_o + ack_o + force_o) <= 1, 1);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req();
    int g = 0;
    while (!request_o && g < 5000) begin tick(1); g++; end
  endtask

  task automatic handshake();
    tick(3);
    chk("R2 request held", request_o, 1);
    done_i = 1;
    tick(1);
    chk("R3 ack on done", ack_o, 1);
    chk("R3 request dropped", request_o, 0);
    tick(2);
    chk("R4 ack held", ack_o, 1);
    done_i = 0;
    tick(1);
    chk("R4 ack released", ack_o, 0);
    chk("R4 no new request", request_o, 0);
  endtask

  initial begin
    int n;
    int sv_rd, sv_ud, sv_ft;
    rst_n = 0; link_event_i = 0; mb_req_i = 0; done_i = 0;
    err_i = 0; rdisp_i = 0; undef_i = 0;
    tick(3);
    chk("R1 reset enable", enable_o, 0);
    chk("R2 reset request", request_o, 0);
    chk("R10 reset count", rdisp_cnt_o, 0);
    rst_n = 1;
    tick(5);
    chk("R1 enable low at edge 5", enable_o, 0);
    tick(1);
    chk("R1 enable high at edge 6", enable_o, 1);
    tick(1);
    chk("R2 power-up request", request_o, 1);
    handshake();

    // source switch, multibyte request queued during handshake
    tick(3);
    link_event_i = 1; tick(1); link_event_i = 0;
    tick(1);
    chk("R2 request after event", request_o, 1);
    mb_req_i = 1; tick(1); mb_req_i = 0;
    handshake();
    tick(1);
    chk("R6 force after ack", force_o, 1);
    n = 1;
    while (force_o && n < 5000) begin
      link_event_i = (n == 100);
      tick(1);
      if (force_o) n++;
    end
    link_event_i = 0;
    chk("R5 force run length", n, FLEN);
    chk("R6 request waits for force end", request_o, 0);
    tick(1);
    chk("R6 queued request after force", request_o, 1);
    handshake();

    // both pending at once: handshake first
    tick(2);
    link_event_i = 1; mb_req_i = 1; tick(1);
    link_event_i = 0; mb_req_i = 0; tick(1);
    chk("R6 priority request", request_o, 1);
    chk("R6 priority no force", force_o, 0);
    handshake();
    tick(1);
    chk("R6 force after priority", force_o, 1);
    while (force_o) tick(1);
    tick(2);

    // error flags
    repeat (3) begin err_i = 1; rdisp_i = 1; undef_i = 0; tick(1); end
    repeat (2) begin err_i = 1; rdisp_i = 0; undef_i = 1; tick(1); end
    err_i = 1; rdisp_i = 1; undef_i = 1; tick(1);
    err_i = 1; rdisp_i = 0; undef_i = 0; tick(1);
    err_i = 0; rdisp_i = 0; undef_i = 0;
    chk("R7 rdisp count", rdisp_cnt_o, 3);
    chk("R7 undef count", undef_cnt_o, 2);
    chk("R9 fault count", fault_cnt_o, 1);
    sv_rd = rdisp_cnt_o; sv_ud = undef_cnt_o; sv_ft = fault_cnt_o;
    rdisp_i = 1; tick(2);
    undef_i = 1; tick(2);
    rdisp_i = 0; tick(2);
    undef_i = 0; tick(1);
    chk("R8 rdisp unchanged", rdisp_cnt_o, sv_rd);
    chk("R8 undef unchanged", undef_cnt_o, sv_ud);
    chk("R8 fault unchanged", fault_cnt_o, sv_ft);

    // saturation
    err_i = 1; rdisp_i = 1;
    tick(CMAX + 5);
    err_i = 0; rdisp_i = 0;
    tick(1);
    chk("R10 saturated rdisp", rdisp_cnt_o, CMAX);
    chk("R10 undef untouched", undef_cnt_o, 2);
    tick(2);
    finish_run();
  end

endmodule